// File: doc/BRIEF.md
# Register-Programmed Display Timing Generator

This block produces the raster timing for a display pipeline on a single pixel clock. It runs a horizontal pixel counter and a vertical line counter, and it drives horizontal sync, vertical sync and a data-enable strobe. It also computes the byte address of every visible pixel, which a separate fetch unit can use to read the frame buffer. All geometry comes from a small bank of 32-bit registers on a byte-addressed write/read port.

Software writes the frame totals, the blanking widths, the sync offsets, a buffer base, a line stride and a control word. It then writes 1 to a trigger register. The trigger arms a working copy, and that copy loads at the last pixel of the frame being scanned, or at once if the generator is stopped. A reprogram therefore never tears a frame. Every two-dimensional timing word holds the horizontal quantity in bits 31:16 and the vertical quantity in bits 15:0. Each quantity is stored as its value minus one. Sync positions are counted from the end of the visible region.

Top module: `disp_timing_gen`

## Requirements
- R1: Out of reset, the counters read 0, de is low, and hsync and vsync are 1 (their inactive level for the default active-low polarity). The control and status registers read 0.
- R2: Registers sit at byte addresses 0x000 (control), 0x010 (totals), 0x014 (hsync offsets), 0x018 (vsync offsets), 0x01C (blanking widths), 0x040 (base), 0x050 (stride) and 0x084 (trigger, reads 0). The timing, base and stride registers read back what was written. Control keeps only bits 4:1, and its other bits read 0.
- R3: 0x3FC reads the ID_VALUE parameter. Status at 0x004 reads the enable state in bit 1 and 0 in every other bit. Writes to 0x3FC and 0x004 change nothing.
- R4: While enabled, X counts 0 to Htot-1, where Htot-1 is totals[31:16]. At the end of a line X returns to 0 and Y advances. Y wraps to 0 after line totals[15:0].
- R5: de is high exactly when enabled, X < W and Y < H. Here W = totals[31:16] - blank[31:16] and H = totals[15:0] - blank[15:0].
- R6: hsync is active for X in [W+s+1, W+e+1), where s is hsync[31:16] and e is hsync[15:0]. vsync is active for Y in [H+s+1, H+e+1), using the vertical fields. Control bit 4 (hsync) and bit 3 (vsync) set to 1 make a sync active-high; cleared, the sync is active-low.
- R7: While control bit 1 is clear, the counters return to 0 on the next clock and de is low. Both syncs sit at their inactive level.
- R8: A write to 0x084 with bit 0 set arms a reload. The working timing, base, stride and pixel width load from the programmed values at the last pixel of the current frame, or on the next clock if disabled. Until then the scan uses the old values.
- R9: pix_addr = base + Y*line_bytes + X*bpp while de is high, and 0 otherwise. bpp is 4 when working control bit 2 is set and 2 when it is clear.
- R10: line_bytes is the stride when the stride is nonzero, and W*bpp when the stride is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| x_pos | output | 16 | Current pixel column |
| y_pos | output | 16 | Current line |
| hsync | output | 1 | Horizontal sync, polarity per control bit 4 |
| vsync | output | 1 | Vertical sync, polarity per control bit 3 |
| de | output | 1 | Visible-pixel strobe |
| pix_addr | output | 32 | Byte address of the current visible pixel |

## Verification
Assertions check the invariants that hold every cycle:
- X never passes the working line total, and the line counter steps at each line end.
- A disabled generator returns to the origin with syncs idle.
- The working copy stays still unless a reload fires.
- The address advances by exactly one pixel width along a line.

Only the bench scenarios can show the absolute values: the register map and the ignored writes, the exact sync windows for each polarity, and the pixel addresses under packed and strided lines. They also show that a mid-frame reprogram leaves the rest of that frame on the old geometry and base.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned FLD_W  = 16;
  localparam int unsigned BUS_AW = 12;

  localparam logic [BUS_AW-1:0] A_CTRL = 12'h000;
  localparam logic [BUS_AW-1:0] A_STAT = 12'h004;
  localparam logic [BUS_AW-1:0] A_TOT  = 12'h010;
  localparam logic [BUS_AW-1:0] A_HSY  = 12'h014;
  localparam logic [BUS_AW-1:0] A_VSY  = 12'h018;
  localparam logic [BUS_AW-1:0] A_BLK  = 12'h01C;
  localparam logic [BUS_AW-1:0] A_BASE = 12'h040;
  localparam logic [BUS_AW-1:0] A_STRD = 12'h050;
  localparam logic [BUS_AW-1:0] A_GO   = 12'h084;
  localparam logic [BUS_AW-1:0] A_ID   = 12'h3FC;

  localparam int unsigned CB_EN   = 1;
  localparam int unsigned CB_WIDE = 2;
  localparam int unsigned CB_VPOL = 3;
  localparam int unsigned CB_HPOL = 4;

  typedef struct packed {
    logic [REG_W-1:0] tot;
    logic [REG_W-1:0] hsy;
    logic [REG_W-1:0] vsy;
    logic [REG_W-1:0] blk;
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] strd;
  } geom_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter logic [REG_W-1:0] ID_VALUE = 32'h4454_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              load,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              en,
  output logic              hpol,
  output logic              vpol,
  output logic              pend,
  output geom_t             work,
  output logic              work_wide
);
  logic [CB_HPOL:CB_EN] ctrl_q, ctrl_n;
  geom_t prog_q, prog_n, work_q, work_n;
  logic  wide_q, wide_n;
  logic  pend_q, pend_n;
  logic  go_wr;

  assign go_wr = bus_wr && (bus_addr == A_GO) && bus_wdata[0];

  always_comb begin
    ctrl_n = ctrl_q;
    prog_n = prog_q;
    if (bus_wr) begin
      case (bus_addr)
        A_CTRL: ctrl_n = bus_wdata[CB_HPOL:CB_EN];
        A_TOT:  prog_n.tot  = bus_wdata;
        A_HSY:  prog_n.hsy  = bus_wdata;
        A_VSY:  prog_n.vsy  = bus_wdata;
        A_BLK:  prog_n.blk  = bus_wdata;
        A_BASE: prog_n.base = bus_wdata;
        A_STRD: prog_n.strd = bus_wdata;
        default: ;
      endcase
    end
    work_n = load ? prog_q : work_q;
    wide_n = load ? ctrl_q[CB_WIDE] : wide_q;
    if (go_wr)     pend_n = 1'b1;
    else if (load) pend_n = 1'b0;
    else           pend_n = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      prog_q <= '0;
      work_q <= '0;
      wide_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      prog_q <= prog_n;
      work_q <= work_n;
      wide_q <= wide_n;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[CB_HPOL:CB_EN] = ctrl_q;
      A_STAT: bus_rdata[1] = ctrl_q[CB_EN];
      A_TOT:  bus_rdata = prog_q.tot;
      A_HSY:  bus_rdata = prog_q.hsy;
      A_VSY:  bus_rdata = prog_q.vsy;
      A_BLK:  bus_rdata = prog_q.blk;
      A_BASE: bus_rdata = prog_q.base;
      A_STRD: bus_rdata = prog_q.strd;
      A_ID:   bus_rdata = ID_VALUE;
      default: ;
    endcase
  end

  assign en        = ctrl_q[CB_EN];
  assign hpol      = ctrl_q[CB_HPOL];
  assign vpol      = ctrl_q[CB_VPOL];
  assign pend      = pend_q;
  assign work      = work_q;
  assign work_wide = wide_q;

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(work_q) && $stable(wide_q)));
endmodule

// File: rtl/dtg_raster.sv
module dtg_raster
  import dtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hpol,
  input  logic             vpol,
  input  geom_t            work,
  output logic [FLD_W-1:0] x_pos,
  output logic [FLD_W-1:0] y_pos,
  output logic [FLD_W-1:0] act_w,
  output logic             de,
  output logic             hsync,
  output logic             vsync,
  output logic             frame_end
);
  localparam int unsigned EW = FLD_W + 1;

  logic [FLD_W-1:0] x_q, x_n, y_q, y_n;
  logic [FLD_W-1:0] htot, vtot, act_h;
  logic [EW-1:0]    hs_beg, hs_end, vs_beg, vs_end;
  logic             line_end, hs_on, vs_on;

  assign htot  = work.tot[2*FLD_W-1:FLD_W];
  assign vtot  = work.tot[FLD_W-1:0];
  assign act_w = htot - work.blk[2*FLD_W-1:FLD_W];
  assign act_h = vtot - work.blk[FLD_W-1:0];

  assign line_end  = (x_q == htot);
  assign frame_end = line_end && (y_q == vtot);

  always_comb begin
    x_n = x_q;
    y_n = y_q;
    if (!en) begin
      x_n = '0;
      y_n = '0;
    end else if (line_end) begin
      x_n = '0;
      y_n = (y_q == vtot) ? '0 : y_q + 1'b1;
    end else begin
      x_n = x_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_n;
      y_q <= y_n;
    end
  end

  assign hs_beg = {1'b0, act_w} + {1'b0, work.hsy[2*FLD_W-1:FLD_W]} + EW'(1);
  assign hs_end = {1'b0, act_w} + {1'b0, work.hsy[FLD_W-1:0]} + EW'(1);
  assign vs_beg = {1'b0, act_h} + {1'b0, work.vsy[2*FLD_W-1:FLD_W]} + EW'(1);
  assign vs_end = {1'b0, act_h} + {1'b0, work.vsy[FLD_W-1:0]} + EW'(1);

  assign hs_on = en && ({1'b0, x_q} >= hs_beg) && ({1'b0, x_q} < hs_end);
  assign vs_on = en && ({1'b0, y_q} >= vs_beg) && ({1'b0, y_q} < vs_end);

  assign hsync = hpol ? hs_on : ~hs_on;
  assign vsync = vpol ? vs_on : ~vs_on;
  assign de    = en && (x_q < act_w) && (y_q < act_h);
  assign x_pos = x_q;
  assign y_pos = y_q;

  // R4
  x_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_q <= htot);
  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && line_end && (y_q != vtot)) |=> (y_q == $past(y_q) + 1'b1));
  // R7
  idle_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (x_q == '0 && y_q == '0));
  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!de && hsync == !hpol && vsync == !vpol));
endmodule

// File: rtl/dtg_addr.sv
module dtg_addr
  import dtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLD_W-1:0] x_pos,
  input  logic [FLD_W-1:0] y_pos,
  input  logic [FLD_W-1:0] act_w,
  input  logic             de,
  input  geom_t            work,
  input  logic             work_wide,
  output logic [REG_W-1:0] pix_addr
);
  logic [1:0]       shamt;
  logic [REG_W-1:0] step, line_bytes, row_off, col_off;

  assign shamt      = work_wide ? 2'd2 : 2'd1;
  assign step       = REG_W'(1) << shamt;
  assign line_bytes = (work.strd == '0) ? (REG_W'(act_w) << shamt) : work.strd;
  assign row_off    = REG_W'(y_pos) * line_bytes;
  assign col_off    = REG_W'(x_pos) << shamt;
  assign pix_addr   = de ? (work.base + row_off + col_off) : '0;

  // R9
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de) && x_pos == $past(x_pos) + 1'b1 && y_pos == $past(y_pos))
    |-> (pix_addr == $past(pix_addr) + step));
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h4454_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [15:0] x_pos,
  output logic [15:0] y_pos,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic [31:0] pix_addr
);
  logic             en, hpol, vpol, pend, load, frame_end, work_wide;
  logic [FLD_W-1:0] act_w;
  geom_t            work;

  assign load = pend && (!en || frame_end);

  dtg_regs #(.ID_VALUE(ID_VALUE)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .load(load), .bus_rdata(bus_rdata), .en(en),
    .hpol(hpol), .vpol(vpol), .pend(pend), .work(work), .work_wide(work_wide)
  );

  dtg_raster raster_i (
    .clk(clk), .rst_n(rst_n), .en(en), .hpol(hpol), .vpol(vpol), .work(work),
    .x_pos(x_pos), .y_pos(y_pos), .act_w(act_w), .de(de), .hsync(hsync),
    .vsync(vsync), .frame_end(frame_end)
  );

  dtg_addr addr_i (
    .clk(clk), .rst_n(rst_n), .x_pos(x_pos), .y_pos(y_pos), .act_w(act_w),
    .de(de), .work(work), .work_wide(work_wide), .pix_addr(pix_addr)
  );
endmodule

// File: tb/disp_timing_gen_tb_top.sv
module disp_timing_gen_tb_top;
  localparam logic [31:0] IDV = 32'h4454_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] x_pos, y_pos;
  logic        hsync, vsync, de;
  logic [31:0] pix_addr;

  int checks = 0;
  int errors = 0;
  int model_fail_prints = 0;
  bit cmp_on = 1'b0;

  // bench-side expectation state
  logic        m_en, m_hpol, m_vpol, m_wide, w_wide, m_pend;
  logic [31:0] p_tot, p_hsy, p_vsy, p_blk, p_base, p_strd;
  logic [31:0] w_tot, w_hsy, w_vsy, w_blk, w_base, w_strd;
  logic [15:0] mx, my;

  disp_timing_gen #(.ID_VALUE(IDV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .x_pos(x_pos), .y_pos(y_pos),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_addr(pix_addr)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_en, m_hpol, m_vpol, m_wide, w_wide, m_pend} = '0;
    {p_tot, p_hsy, p_vsy, p_blk, p_base, p_strd} = '0;
    {w_tot, w_hsy, w_vsy, w_blk, w_base, w_strd} = '0;
    mx = '0; my = '0;
  endtask

  // one rising edge of the expectation model, from the requirements
  task automatic model_edge();
    logic fe, ld;
    fe = (mx == w_tot[31:16]) && (my == w_tot[15:0]);
    ld = m_pend && (!m_en || fe);
    if (!m_en) begin mx = '0; my = '0; end
    else if (mx == w_tot[31:16]) begin
      mx = '0;
      my = (my == w_tot[15:0]) ? 16'd0 : my + 16'd1;
    end else mx = mx + 16'd1;
    if (ld) begin
      w_tot = p_tot; w_hsy = p_hsy; w_vsy = p_vsy; w_blk = p_blk;
      w_base = p_base; w_strd = p_strd; w_wide = m_wide;
    end
    if (bus_wr && bus_addr == 12'h084 && bus_wdata[0]) m_pend = 1'b1;
    else if (ld) m_pend = 1'b0;
    if (bus_wr) begin
      case (bus_addr)
        12'h000: begin m_en = bus_wdata[1]; m_wide = bus_wdata[2];
                       m_vpol = bus_wdata[3]; m_hpol = bus_wdata[4]; end
        12'h010: p_tot = bus_wdata;
        12'h014: p_hsy = bus_wdata;
        12'h018: p_vsy = bus_wdata;
        12'h01C: p_blk = bus_wdata;
        12'h040: p_base = bus_wdata;
        12'h050: p_strd = bus_wdata;
        default: ;
      endcase
    end
  endtask

  task automatic model_compare();
    logic [15:0] w, h;
    logic [16:0] xe, ye;
    logic        e_de, hs_on, vs_on, e_hs, e_vs;
    logic [31:0] bpp, line, e_addr;
    w = w_tot[31:16] - w_blk[31:16];
    h = w_tot[15:0] - w_blk[15:0];
    xe = {1'b0, mx}; ye = {1'b0, my};
    e_de = m_en && mx < w && my < h;
    hs_on = m_en && xe >= ({1'b0,w} + {1'b0,w_hsy[31:16]} + 17'd1)
                 && xe <  ({1'b0,w} + {1'b0,w_hsy[15:0]} + 17'd1);
    vs_on = m_en && ye >= ({1'b0,h} + {1'b0,w_vsy[31:16]} + 17'd1)
                 && ye <  ({1'b0,h} + {1'b0,w_vsy[15:0]} + 17'd1);
    e_hs = m_hpol ? hs_on : !hs_on;
    e_vs = m_vpol ? vs_on : !vs_on;
    bpp = w_wide ? 32'd4 : 32'd2;
    line = (w_strd == 0) ? 32'(w) * bpp : w_strd;
    e_addr = e_de ? w_base + 32'(my) * line + 32'(mx) * bpp : 32'd0;
    checks++;
    if (x_pos !== mx || y_pos !== my || de !== e_de || hsync !== e_hs ||
        vsync !== e_vs || pix_addr !== e_addr) begin
      errors++;
      if (model_fail_prints < 20) begin
        model_fail_prints++;
        $display("FAIL R4 R5 R6 R9 R10 actual x=%0d y=%0d de=%b hs=%b vs=%b a=%h expected x=%0d y=%0d de=%b hs=%b vs=%b a=%h",
                 x_pos, y_pos, de, hsync, vsync, pix_addr, mx, my, e_de, e_hs, e_vs, e_addr);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (cmp_on) model_compare();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic t_reset();
    chk("R1 x", 32'(x_pos), 0);
    chk("R1 y", 32'(y_pos), 0);
    chk("R1 de", 32'(de), 0);
    chk("R1 hsync", 32'(hsync), 1);
    chk("R1 vsync", 32'(vsync), 1);
    rd_chk("R1 ctrl", 12'h000, 0);
    rd_chk("R1 status", 12'h004, 0);
  endtask

  task automatic t_regs();
    wr(12'h010, 32'h1234_5678);
    wr(12'h014, 32'hA5A5_0F0F);
    wr(12'h018, 32'h0001_0002);
    wr(12'h01C, 32'hFFFF_0000);
    wr(12'h040, 32'hDEAD_BEE0);
    wr(12'h050, 32'h0000_1000);
    rd_chk("R2 totals", 12'h010, 32'h1234_5678);
    rd_chk("R2 hsync", 12'h014, 32'hA5A5_0F0F);
    rd_chk("R2 vsync", 12'h018, 32'h0001_0002);
    rd_chk("R2 blank", 12'h01C, 32'hFFFF_0000);
    rd_chk("R2 base", 12'h040, 32'hDEAD_BEE0);
    rd_chk("R2 stride", 12'h050, 32'h0000_1000);
    rd_chk("R2 trigger", 12'h084, 0);
    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl bits", 12'h000, 32'h0000_001E);
    rd_chk("R3 status busy", 12'h004, 32'h0000_0002);
    wr(12'h000, 32'h0);
    ticks(2);
  endtask

  task automatic t_ignored();
    wr(12'h3FC, 32'h0);
    wr(12'h004, 32'hFFFF_FFFF);
    rd_chk("R3 id", 12'h3FC, IDV);
    rd_chk("R3 status unchanged", 12'h004, 0);
    rd_chk("R3 ctrl unchanged", 12'h000, 0);
    chk("R3 x after status write", 32'(x_pos), 0);
  endtask

  // 10x6 frame, 6x4 visible, hsync x 7..8, vsync line 5, base 0x1000, 16bpp packed
  task automatic t_frame();
    wr(12'h010, {16'd9, 16'd5});
    wr(12'h014, {16'd0, 16'd2});
    wr(12'h018, {16'd0, 16'd1});
    wr(12'h01C, {16'd3, 16'd1});
    wr(12'h040, 32'h0000_1000);
    wr(12'h050, 32'h0);
    wr(12'h084, 32'h1);
    tick();
    wr(12'h000, 32'h0000_000A);
    chk("R5 de at origin", 32'(de), 1);
    chk("R9 addr at origin", pix_addr, 32'h1000);
    ticks(7);
    chk("R6 hsync active-low at x7", 32'(hsync), 0);
    chk("R5 de low in blank", 32'(de), 0);
    ticks(6);
    chk("R10 packed line addr x3 y1", pix_addr, 32'h1012);
    ticks(37);
    chk("R6 vsync active-high line5", 32'(vsync), 1);
    chk("R4 y at line5", 32'(y_pos), 5);
    ticks(10);
    chk("R4 wrap x", 32'(x_pos), 0);
    chk("R4 wrap y", 32'(y_pos), 0);
  endtask

  // reprogram mid-frame: 32bpp, stride 0x40, blank 2 (W=8), base 0x2000
  task automatic t_shadow();
    wr(12'h01C, {16'd1, 16'd1});
    wr(12'h040, 32'h0000_2000);
    wr(12'h050, 32'h0000_0040);
    wr(12'h000, 32'h0000_000E);
    wr(12'h084, 32'h1);
    chk("R8 old base and width mid-frame", pix_addr, 32'h100A);
    ticks(55);
    chk("R8 new base at next frame", pix_addr, 32'h2000);
    ticks(7);
    chk("R8 new width de at x7", 32'(de), 1);
    chk("R9 32bpp addr x7", pix_addr, 32'h201C);
    chk("R6 hsync idle at x7", 32'(hsync), 1);
    ticks(10);
    chk("R10 stride line addr", pix_addr, 32'h205C);
  endtask

  task automatic t_polarity();
    wr(12'h000, 32'h0000_0016);
    tick();
    chk("R6 x at 9", 32'(x_pos), 9);
    chk("R6 hsync active-high", 32'(hsync), 1);
    chk("R6 vsync idle high when active-low", 32'(vsync), 1);
  endtask

  task automatic t_disable();
    wr(12'h000, 32'h0000_0010);
    chk("R7 de low at once", 32'(de), 0);
    chk("R7 hsync idle low", 32'(hsync), 0);
    ticks(2);
    chk("R7 x held", 32'(x_pos), 0);
    chk("R7 y held", 32'(y_pos), 0);
    chk("R7 vsync idle", 32'(vsync), 1);
    rd_chk("R3 status idle", 12'h004, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cmp_on = 1'b1;
    tick();
    t_regs();
    t_ignored();
    t_frame();
    t_shadow();
    t_polarity();
    t_disable();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule